// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block sits between two slow external control pins and the output stage of a two-output clock generator. One output is the main clock and the other is a reference clock that can carry either the master clock or a prescaled version of it. Four configuration bits decide the role of each pin. The reference pin can act as a mux select, an output enable or a shutdown request. The main pin can act as an output enable or a shutdown request. The block produces a drive-enable for each output, where low means high impedance, plus the reference mux select and a device power-down flag.

Both pins are synchronised to the master clock. Output disables take effect only while the output level is low, so no runt pulse appears on a pad. A shutdown request must persist for a programmable number of rising edges of the slow main output before it is honoured. The shutdown sequence first parks both outputs and then raises the power-down flag. Leaving power-down, and leaving reset, both start a hold-off during which the outputs stay disabled until the oscillator has settled.

Top module: `clk_oe_pd_ctrl`

## Requirements
- R1: Each control pin passes through two synchronising flops. A pin change made before clock edge 1 can alter an enable or the mux select at edge 3 at the earliest, and never sooner.
- R2: With the reference power-down bit set, the reference pin is a shutdown request (1 = shut down), whatever the enable and select bits hold. While running, the reference output is enabled and the mux select equals the select bit (0 = master clock, 1 = prescaled clock).
- R3: With the reference power-down bit clear and the enable bit set, the reference pin is an active-low enable for the reference output (0 = drive, 1 = high impedance). The mux select equals the select bit.
- R4: With enable = 0, select = 1 and reference power-down = 0, the reference output is enabled and the mux select follows the synchronised reference pin (0 = master clock, 1 = prescaled clock).
- R5: With enable, select and reference power-down all 0, the reference output is never enabled and the reference pin is a shutdown request (1 = shut down).
- R6: With its power-down bit clear, the main pin is an active-low enable for the main output. With the bit set, the main pin is a shutdown request and the main output is enabled while running.
- R7: The shutdown requests from the two pins are ORed. The device stays powered down while any configured request is active.
- R8: An enable that drops takes effect only on a clock edge where that output's level is low. An enable that rises takes effect at once.
- R9: A shutdown first clears both output enables and only then raises the power-down flag. Both enables stay low while the flag is high.
- R10: After reset, and after the power-down flag falls, both enables stay low for STARTUP_CYCLES master clock cycles.
- R11: A shutdown request is honoured only after it has stayed active across at least pd_min_edges rising edges of the main output level. A shorter request leaves the power-down flag low.
- R12: During reset both enables, the mux select and the power-down flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pin_async | input | 1 | Reference control pin, asynchronous |
| main_pin_async | input | 1 | Main control pin, asynchronous |
| cfg_ref_en | input | 1 | Reference pin acts as output enable |
| cfg_ref_sel | input | 1 | Reference source select / mux-select mode |
| cfg_ref_pd | input | 1 | Reference pin acts as shutdown request |
| cfg_main_pd | input | 1 | Main pin acts as shutdown request |
| pd_min_edges | input | PD_CNT_W | Minimum main-level rising edges before a shutdown is honoured |
| ref_clk_lvl | input | 1 | Current level of the reference output clock |
| main_clk_lvl | input | 1 | Current level of the main output clock |
| ref_oe | output | 1 | Reference output drive enable (0 = high impedance) |
| main_oe | output | 1 | Main output drive enable (0 = high impedance) |
| ref_mux_sel | output | 1 | Reference mux select (0 = master, 1 = prescaled) |
| pwr_down | output | 1 | Device power-down flag |

## Verification
The assertions assume that the two clock-level inputs really toggle while an output is being parked, so that a disable can complete. They also assume the configuration bits change only between stimulus phases and not while a shutdown sequence is running. The stimulus keeps to this: both levels run free except in short directed windows that hold a level on purpose, and every randomised configuration is applied and then left to settle. Random pin values are masked so that no shutdown request fires by accident outside the directed shutdown tests.

// File: rtl/clk_oe_pd_pkg.sv
package clk_oe_pd_pkg;

    typedef enum logic [1:0] {
        SEQ_START = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2,
        SEQ_DOWN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ref_en;
        logic ref_sel;
        logic ref_pd;
        logic main_pd;
    } pin_cfg_t;

    typedef struct packed {
        logic ref_want;
        logic main_want;
        logic mux_sel;
        logic ref_pd_req;
        logic main_pd_req;
    } pin_role_t;

    // Maps the configuration and synchronised pins to the requested output state.
    function automatic pin_role_t decode_roles(pin_cfg_t c, logic ref_pin, logic main_pin);
        pin_role_t r;
        r = '0;
        if (c.ref_pd) begin
            r.ref_want   = 1'b1;
            r.mux_sel    = c.ref_sel;
            r.ref_pd_req = ref_pin;
        end else if (c.ref_en) begin
            r.ref_want = ~ref_pin;
            r.mux_sel  = c.ref_sel;
        end else if (c.ref_sel) begin
            r.ref_want = 1'b1;
            r.mux_sel  = ref_pin;
        end else begin
            r.ref_want   = 1'b0;
            r.mux_sel    = 1'b0;
            r.ref_pd_req = ref_pin;
        end
        if (c.main_pd) begin
            r.main_want   = 1'b1;
            r.main_pd_req = main_pin;
        end else begin
            r.main_want = ~main_pin;
        end
        return r;
    endfunction

endpackage

// File: rtl/clk_oe_sync.sv
module clk_oe_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[i];
                stab_q <= meta_q;
            end
        end
        assign q_sync[i] = stab_q;
    end
endmodule

// File: rtl/clk_oe_role_decode.sv
module clk_oe_role_decode
    import clk_oe_pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_cfg_t  cfg,
    input  logic      ref_pin,
    input  logic      main_pin,
    output pin_role_t role,
    output logic      pd_req,
    output logic      mux_sel_q
);
    assign role   = decode_roles(cfg, ref_pin, main_pin);
    assign pd_req = role.ref_pd_req | role.main_pd_req;

    always_ff @(posedge clk) begin
        if (rst) mux_sel_q <= 1'b0;
        else     mux_sel_q <= role.mux_sel;
    end
endmodule

// File: rtl/clk_oe_pd_qualify.sv
module clk_oe_pd_qualify #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_req,
    input  logic             slow_lvl,
    input  logic [CNT_W-1:0] min_edges,
    output logic             pd_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             lvl_q;
    logic [CNT_W-1:0] edge_cnt;
    logic             slow_rise;

    assign slow_rise = slow_lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= 1'b0;
            edge_cnt <= '0;
        end else begin
            lvl_q <= slow_lvl;
            if (!pd_req)
                edge_cnt <= '0;
            else if (slow_rise && edge_cnt != CNT_MAX)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign pd_ok = pd_req && (edge_cnt >= min_edges);
endmodule

// File: rtl/clk_oe_out_gate.sv
module clk_oe_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic lvl,
    output logic oe
);
    always_ff @(posedge clk) begin
        if (rst)       oe <= 1'b0;
        else if (want) oe <= 1'b1;
        else if (!lvl) oe <= 1'b0;
    end
endmodule

// File: rtl/clk_oe_power_seq.sv
module clk_oe_power_seq
    import clk_oe_pd_pkg::*;
#(
    parameter int STARTUP_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic pd_ok,
    input  logic outs_parked,
    output logic run,
    output logic pwr_down
);
    localparam int SW = $clog2(STARTUP_CYCLES + 1);
    localparam logic [SW-1:0] LAST = SW'(STARTUP_CYCLES - 1);

    seq_state_e      state_q;
    logic [SW-1:0]   wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_START;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_START: begin
                    if (wait_q == LAST) begin
                        state_q <= SEQ_RUN;
                        wait_q  <= '0;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (pd_ok) state_q <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    if (!pd_req)          state_q <= SEQ_RUN;
                    else if (outs_parked) state_q <= SEQ_DOWN;
                end
                SEQ_DOWN: begin
                    if (!pd_req) begin
                        state_q <= SEQ_START;
                        wait_q  <= '0;
                    end
                end
                default: state_q <= SEQ_START;
            endcase
        end
    end

    assign run      = (state_q == SEQ_RUN);
    assign pwr_down = (state_q == SEQ_DOWN);
endmodule

// File: rtl/clk_oe_pd_ctrl.sv
module clk_oe_pd_ctrl
    import clk_oe_pd_pkg::*;
#(
    parameter int STARTUP_CYCLES = 8000,
    parameter int PD_CNT_W       = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_pin_async,
    input  logic                main_pin_async,
    input  logic                cfg_ref_en,
    input  logic                cfg_ref_sel,
    input  logic                cfg_ref_pd,
    input  logic                cfg_main_pd,
    input  logic [PD_CNT_W-1:0] pd_min_edges,
    input  logic                ref_clk_lvl,
    input  logic                main_clk_lvl,
    output logic                ref_oe,
    output logic                main_oe,
    output logic                ref_mux_sel,
    output logic                pwr_down
);
    localparam int NUM_OUT = 2;

    logic [NUM_OUT-1:0] pins_sync;
    pin_cfg_t           cfg;
    pin_role_t          role;
    logic               pd_req;
    logic               pd_ok;
    logic               run;
    logic [NUM_OUT-1:0] want;
    logic [NUM_OUT-1:0] lvl;
    logic [NUM_OUT-1:0] oe;

    assign cfg = '{ref_en: cfg_ref_en, ref_sel: cfg_ref_sel,
                   ref_pd: cfg_ref_pd, main_pd: cfg_main_pd};

    clk_oe_sync #(.WIDTH(NUM_OUT)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({main_pin_async, ref_pin_async}),
        .q_sync  (pins_sync)
    );

    clk_oe_role_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .ref_pin   (pins_sync[0]),
        .main_pin  (pins_sync[1]),
        .role      (role),
        .pd_req    (pd_req),
        .mux_sel_q (ref_mux_sel)
    );

    clk_oe_pd_qualify #(.CNT_W(PD_CNT_W)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .pd_req    (pd_req),
        .slow_lvl  (main_clk_lvl),
        .min_edges (pd_min_edges),
        .pd_ok     (pd_ok)
    );

    clk_oe_power_seq #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .pd_req      (pd_req),
        .pd_ok       (pd_ok),
        .outs_parked (oe == '0),
        .run         (run),
        .pwr_down    (pwr_down)
    );

    assign want = {run & role.main_want, run & role.ref_want};
    assign lvl  = {main_clk_lvl, ref_clk_lvl};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
        clk_oe_out_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .want (want[g]),
            .lvl  (lvl[g]),
            .oe   (oe[g])
        );
    end

    assign ref_oe  = oe[0];
    assign main_oe = oe[1];
endmodule

// File: rtl/clk_oe_pd_ctrl_chk.sv
module clk_oe_pd_ctrl_chk #(
    parameter int STARTUP_CYCLES = 8000
) (
    input logic clk,
    input logic rst,
    input logic ref_clk_lvl,
    input logic main_clk_lvl,
    input logic ref_oe,
    input logic main_oe,
    input logic pwr_down
);
    int unsigned since_up;

    always_ff @(posedge clk) begin
        if (rst || pwr_down)               since_up <= 0;
        else if (since_up < STARTUP_CYCLES) since_up <= since_up + 1;
    end

    // R8
    ref_park_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_oe) |-> !$past(ref_clk_lvl));

    // R8
    main_park_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(main_oe) |-> !$past(main_clk_lvl));

    // R9
    down_parked_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!ref_oe && !main_oe));

    // R10
    startup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since_up < STARTUP_CYCLES) |-> (!ref_oe && !main_oe));
endmodule

bind clk_oe_pd_ctrl clk_oe_pd_ctrl_chk #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ref_clk_lvl  (ref_clk_lvl),
    .main_clk_lvl (main_clk_lvl),
    .ref_oe       (ref_oe),
    .main_oe      (main_oe),
    .pwr_down     (pwr_down)
);

// File: tb/clk_oe_pd_ctrl_test.sv
`timescale 1ns/1ps
module clk_oe_pd_ctrl_test;
    localparam int STARTUP = 100;
    localparam int CW      = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pin = 1'b0, main_pin = 1'b0;
    logic c_en = 1'b1, c_sel = 1'b1, c_rpd = 1'b0, c_mpd = 1'b0;
    logic [CW-1:0] min_edges = 8'd3;
    logic ref_lvl = 1'b0, main_lvl = 1'b0;
    logic ref_auto = 1'b1, ref_force = 1'b0;
    logic ref_oe, main_oe, mux_sel, pwr_down;

    int checks = 0, failures = 0, overlap = 0;
    bit done = 1'b0;
    int unsigned main_div = 0;

    always #2.5 clk = ~clk;

    clk_oe_pd_ctrl #(.STARTUP_CYCLES(STARTUP), .PD_CNT_W(CW)) uut (
        .clk(clk), .rst(rst),
        .ref_pin_async(ref_pin), .main_pin_async(main_pin),
        .cfg_ref_en(c_en), .cfg_ref_sel(c_sel), .cfg_ref_pd(c_rpd), .cfg_main_pd(c_mpd),
        .pd_min_edges(min_edges),
        .ref_clk_lvl(ref_lvl), .main_clk_lvl(main_lvl),
        .ref_oe(ref_oe), .main_oe(main_oe), .ref_mux_sel(mux_sel), .pwr_down(pwr_down)
    );

    // Clock-level generators: reference toggles every cycle, main every four.
    always @(negedge clk) begin
        ref_lvl  <= ref_auto ? ~ref_lvl : ref_force;
        main_div <= main_div + 1;
        if (main_div % 4 == 3) main_lvl <= ~main_lvl;
        if (!rst && pwr_down && (ref_oe || main_oe)) overlap <= overlap + 1;
    end

    // Expected reference enable while running.
    function automatic logic exp_ref_on(logic en, logic sel, logic rpd, logic pin);
        if (rpd)      return 1'b1;
        else if (en)  return ~pin;
        else if (sel) return 1'b1;
        else          return 1'b0;
    endfunction

    function automatic logic exp_mux(logic en, logic sel, logic rpd, logic pin);
        if (rpd || en) return sel;
        else if (sel)  return pin;
        else           return 1'b0;
    endfunction

    function automatic logic exp_main_on(logic mpd, logic pin);
        return mpd ? 1'b1 : ~pin;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        bit saw_down;
        seed = $urandom(32'hC10C);

        // R12 reset state
        tick(4);
        chk("R12 ref_oe", ref_oe, 1'b0);
        chk("R12 main_oe", main_oe, 1'b0);
        chk("R12 mux", mux_sel, 1'b0);
        chk("R12 pwr_down", pwr_down, 1'b0);
        rst = 1'b0;

        // R10 startup hold after reset
        tick(STARTUP / 2);
        chk("R10 ref_oe hold", ref_oe, 1'b0);
        chk("R10 main_oe hold", main_oe, 1'b0);
        tick(STARTUP);
        chk("R3 ref_oe on", ref_oe, 1'b1);
        chk("R6 main_oe on", main_oe, 1'b1);
        chk("R3 mux follows sel", mux_sel, 1'b1);

        // R1 latency through the synchroniser, level held low
        ref_auto = 1'b0; ref_force = 1'b0;
        tick(3);
        ref_pin = 1'b1;
        tick(2);
        chk("R1 no change after two edges", ref_oe, 1'b1);
        tick(1);
        chk("R1 change at third edge", ref_oe, 1'b0);

        // R8 disable waits for low level, enable is immediate
        ref_pin = 1'b0;
        tick(5);
        ref_force = 1'b1;
        tick(2);
        ref_pin = 1'b1;
        tick(10);
        chk("R8 disable held while level high", ref_oe, 1'b1);
        ref_force = 1'b0;
        tick(2);
        chk("R8 disable once level low", ref_oe, 1'b0);
        ref_force = 1'b1;
        tick(2);
        ref_pin = 1'b0;
        tick(3);
        chk("R8 enable while level high", ref_oe, 1'b1);
        ref_auto = 1'b1;

        // R4 mux-select mode
        c_en = 1'b0; c_sel = 1'b1; c_rpd = 1'b0;
        ref_pin = 1'b0;
        tick(8);
        chk("R4 mux master", mux_sel, 1'b0);
        chk("R4 ref_oe", ref_oe, 1'b1);
        ref_pin = 1'b1;
        tick(8);
        chk("R4 mux prescaled", mux_sel, 1'b1);
        chk("R4 ref_oe", ref_oe, 1'b1);

        // Random configurations, shutdown requests masked off
        for (int it = 0; it < 40; it++) begin
            {c_en, c_sel, c_rpd, c_mpd} = 4'($urandom_range(0, 15));
            ref_pin  = 1'($urandom_range(0, 1));
            main_pin = 1'($urandom_range(0, 1));
            if (c_rpd || (!c_en && !c_sel)) ref_pin = 1'b0;
            if (c_mpd) main_pin = 1'b0;
            tick(14);
            chk(c_rpd ? "R2 rand ref_oe" : c_en ? "R3 rand ref_oe" :
                c_sel ? "R4 rand ref_oe" : "R5 rand ref_oe",
                ref_oe, exp_ref_on(c_en, c_sel, c_rpd, ref_pin));
            chk(c_rpd ? "R2 rand mux" : c_en ? "R3 rand mux" : "R4 rand mux",
                mux_sel, exp_mux(c_en, c_sel, c_rpd, ref_pin));
            chk("R6 rand main_oe", main_oe, exp_main_on(c_mpd, main_pin));
            chk("R7 rand no shutdown", pwr_down, 1'b0);
        end

        // R11 short shutdown request on the main pin is ignored
        c_en = 1'b1; c_sel = 1'b1; c_rpd = 1'b0; c_mpd = 1'b1;
        ref_pin = 1'b0; main_pin = 1'b0;
        tick(10);
        main_pin = 1'b1;
        saw_down = 1'b0;
        for (int k = 0; k < 12; k++) begin tick(1); if (pwr_down) saw_down = 1'b1; end
        main_pin = 1'b0;
        for (int k = 0; k < 20; k++) begin tick(1); if (pwr_down) saw_down = 1'b1; end
        chk("R11 short request ignored", saw_down, 1'b0);
        chk("R11 main_oe kept", main_oe, 1'b1);

        // R6 R9 sustained request on the main pin
        main_pin = 1'b1;
        tick(80);
        chk("R6 main pin shutdown", pwr_down, 1'b1);
        chk("R9 ref parked", ref_oe, 1'b0);
        chk("R9 main parked", main_oe, 1'b0);
        main_pin = 1'b0;
        tick(5);
        chk("R10 flag released", pwr_down, 1'b0);
        chk("R10 main hold after exit", main_oe, 1'b0);
        tick(STARTUP + 10);
        chk("R6 main_oe in shutdown mode", main_oe, 1'b1);

        // R5 R7 reference pin shuts down in all-zero mode
        c_en = 1'b0; c_sel = 1'b0;
        tick(10);
        chk("R5 ref never enabled", ref_oe, 1'b0);
        ref_pin = 1'b1;
        tick(80);
        chk("R5 ref pin shutdown", pwr_down, 1'b1);
        ref_pin = 1'b0;
        tick(STARTUP + 15);
        chk("R5 up again", pwr_down, 1'b0);
        chk("R5 ref stays off", ref_oe, 1'b0);

        // R2 reference power-down mode, select = master
        c_rpd = 1'b1; c_sel = 1'b0; c_en = 1'b1;
        tick(10);
        chk("R2 ref_oe", ref_oe, 1'b1);
        chk("R2 mux", mux_sel, 1'b0);
        ref_pin = 1'b1;
        tick(80);
        chk("R2 ref pin shutdown", pwr_down, 1'b1);

        // R7 both requests ORed
        main_pin = 1'b1;
        tick(5);
        ref_pin = 1'b0;
        tick(40);
        chk("R7 held by main pin", pwr_down, 1'b1);
        main_pin = 1'b0;
        tick(5);
        chk("R7 released", pwr_down, 1'b0);
        tick(STARTUP + 10);
        chk("R2 ref_oe after restart", ref_oe, 1'b1);

        chk("R9 no enable while down", overlap == 0, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule